// File: doc/BRIEF.md
# Trusted Routine Key Access Monitor

This block sits beside the core of a small microcontroller and guards a secret-key region of the data address space. It watches the program counter and the instruction-fetch strobe, the data-bus address and read strobe, interrupt requests and DMA requests. The key can only be read while a trusted flag is set and the program counter is inside the trusted ROM routine. That flag can only be set by a fetch at the routine's single entry address, and it can only be cleared legally by leaving the routine straight after the exit address has been fetched.

While the routine runs, the monitor masks interrupts and withholds DMA grants, so the routine runs without interruption. A blocked key read returns zero on the read data path in the same cycle it happens. Every violation starts a registered reset pulse to the core that lasts a fixed number of cycles and clears the trusted flag. The monitor uses only signals the core already exposes, and all addresses are parameters.

Top module: `key_access_monitor`

## Requirements
- R1: After reset, `core_rst_o` is 0 and `trusted_o` is 0. Interrupts pass unchanged to `irq_o`, and DMA requests pass unchanged to `dma_gnt_o`.
- R2: A read (`dbus_rd_i`=1) of an address in [KEY_BASE, KEY_BASE+KEY_LEN-1] while `trusted_o`=0, or while `pc_i` is outside the ROM, drives `cpu_rdata_o` to zero in the same cycle and is a violation.
- R3: A key read while `trusted_o`=1 and `pc_i` is inside [ROM_BASE, ROM_BASE+ROM_SIZE-1] returns `mem_rdata_i` unchanged. Any read outside the key range also returns `mem_rdata_i` unchanged. Neither case is a violation.
- R4: A fetch (`pc_valid_i`=1) with `pc_i`=ROM_ENTRY while `trusted_o`=0 sets `trusted_o` on the next cycle.
- R5: A fetch of any ROM address other than ROM_ENTRY while `trusted_o`=0 is a violation.
- R6: While `trusted_o`=1, a fetch outside the ROM whose previous fetch was ROM_EXIT clears `trusted_o` on the next cycle, with no violation.
- R7: While `trusted_o`=1, a fetch outside the ROM whose previous fetch was not ROM_EXIT is a violation.
- R8: `irq_o` is 0 whenever `trusted_o`=1 and in the cycle of a legal entry fetch. Otherwise it equals `irq_i`.
- R9: `dma_gnt_o` is 0 whenever `trusted_o`=1 and in the cycle of a legal entry fetch. Otherwise it equals `dma_req_i`.
- R10: A violation in cycle N makes `core_rst_o` 1 from cycle N+1 for exactly RST_LEN cycles. It also makes `trusted_o` 0 from cycle N+1.
- R11: While `core_rst_o`=1, fetches and key reads cause no violation, do not extend the pulse and cannot set `trusted_o`. Key data is still returned as zero while the pulse is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| pc_i | input | AW | Current program counter |
| pc_valid_i | input | 1 | Instruction fetch at `pc_i` this cycle |
| dbus_addr_i | input | AW | Data-bus address |
| dbus_rd_i | input | 1 | Data-bus read strobe |
| mem_rdata_i | input | DW | Read data from memory |
| cpu_rdata_o | output | DW | Read data to the core, zeroed for blocked key reads |
| irq_i | input | 1 | Interrupt request from peripherals |
| irq_o | output | 1 | Interrupt request to the core after masking |
| dma_req_i | input | 1 | DMA request |
| dma_gnt_o | output | 1 | DMA grant after blocking |
| trusted_o | output | 1 | Trusted routine is executing |
| core_rst_o | output | 1 | Reset request to the core |

## Verification
Read-data gating and the interrupt and DMA masks are combinational. They are due in the same cycle as the stimulus, so the bench drives inputs on the falling edge and compares these outputs one time unit later, before the next rising edge. `trusted_o` and `core_rst_o` are registered and change one rising edge after the stimulus, so the bench checks them one time unit after that edge. The reset pulse is then followed edge by edge for RST_LEN cycles. A reference model in the bench advances its own flag, last-fetch and pulse counter at each step, and every expected value comes from that model.

// File: rtl/amon_pkg.sv
package amon_pkg;

  // Cause of a detected violation, listed in priority order.
  typedef enum logic [1:0] {
    VK_NONE  = 2'd0,
    VK_KEY   = 2'd1,
    VK_ENTRY = 2'd2,
    VK_EXIT  = 2'd3
  } viol_kind_e;

endpackage

// File: rtl/amon_range.sv
module amon_range #(
  parameter int unsigned AW   = 16,
  parameter int unsigned BASE = 0,
  parameter int unsigned SIZE = 1
) (
  input  logic [AW-1:0] addr_i,
  output logic          hit_o
);

  localparam logic [AW-1:0] LO = AW'(BASE);
  localparam logic [AW-1:0] HI = AW'(BASE + SIZE - 1);

  generate
    if (BASE == 0) begin : g_zero_base
      assign hit_o = (addr_i <= HI);
    end else begin : g_offset_base
      assign hit_o = (addr_i >= LO) && (addr_i <= HI);
    end
  endgenerate

endmodule

// File: rtl/amon_seq.sv
module amon_seq
  import amon_pkg::*;
#(
  parameter int unsigned AW        = 16,
  parameter int unsigned ROM_ENTRY = 'hE010,
  parameter int unsigned ROM_EXIT  = 'hE0F0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold_i,
  input  logic          fetch_i,
  input  logic [AW-1:0] pc_i,
  input  logic          pc_in_rom_i,
  input  logic          key_rd_i,
  output logic          trusted_o,
  output logic          entering_o,
  output logic          key_block_o,
  output logic          viol_o
);

  localparam logic [AW-1:0] ENTRY_A = AW'(ROM_ENTRY);
  localparam logic [AW-1:0] EXIT_A  = AW'(ROM_EXIT);

  logic          trusted_q, trusted_d;
  logic [AW-1:0] last_pc_q, last_pc_d;
  logic          last_pc_en;
  logic          legal_entry, bad_entry, leaving, bad_exit, key_ok;
  viol_kind_e    kind;

  always_comb begin
    legal_entry = fetch_i && (pc_i == ENTRY_A) && !trusted_q;
    bad_entry   = fetch_i && pc_in_rom_i && (pc_i != ENTRY_A) && !trusted_q;
    leaving     = fetch_i && !pc_in_rom_i && trusted_q;
    bad_exit    = leaving && (last_pc_q != EXIT_A);
    key_ok      = trusted_q && pc_in_rom_i;
  end

  always_comb begin
    kind = VK_NONE;
    if (!hold_i) begin
      if (key_rd_i && !key_ok) kind = VK_KEY;
      else if (bad_entry)      kind = VK_ENTRY;
      else if (bad_exit)       kind = VK_EXIT;
    end
  end

  assign viol_o      = (kind != VK_NONE);
  assign key_block_o = key_rd_i && !key_ok;
  assign entering_o  = legal_entry && !hold_i;
  assign trusted_o   = trusted_q;

  always_comb begin
    trusted_d = trusted_q;
    if (hold_i || viol_o) trusted_d = 1'b0;
    else if (legal_entry) trusted_d = 1'b1;
    else if (leaving)     trusted_d = 1'b0;
  end

  assign last_pc_en = fetch_i;
  assign last_pc_d  = pc_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trusted_q <= 1'b0;
    end else begin
      trusted_q <= trusted_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_pc_q <= '0;
    end else if (last_pc_en) begin
      last_pc_q <= last_pc_d;
    end
  end

  AST_ENTRY_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_i && pc_i == ENTRY_A && !trusted_q && !hold_i && !key_rd_i) |=> trusted_q); // R4
  AST_LEAVE_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (trusted_q && fetch_i && !pc_in_rom_i) |=> !trusted_q); // R6
  AST_HOLD_NO_TRUST: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> !trusted_q); // R11

endmodule

// File: rtl/amon_rst_pulse.sv
module amon_rst_pulse #(
  parameter int unsigned RST_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  output logic rst_o
);

  localparam int unsigned CW = $clog2(RST_LEN + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = trig_i || (cnt_q != '0);
    if (trig_i) cnt_d = CW'(RST_LEN);
    else        cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign rst_o = (cnt_q != '0);

  AST_TRIG_STARTS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    trig_i |=> rst_o); // R10

endmodule

// File: rtl/key_access_monitor.sv
module key_access_monitor #(
  parameter int unsigned AW        = 16,
  parameter int unsigned DW        = 8,
  parameter int unsigned ROM_BASE  = 'hE000,
  parameter int unsigned ROM_SIZE  = 'h0100,
  parameter int unsigned ROM_ENTRY = 'hE010,
  parameter int unsigned ROM_EXIT  = 'hE0F0,
  parameter int unsigned KEY_BASE  = 'h0A00,
  parameter int unsigned KEY_LEN   = 16,
  parameter int unsigned RST_LEN   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] pc_i,
  input  logic          pc_valid_i,
  input  logic [AW-1:0] dbus_addr_i,
  input  logic          dbus_rd_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [DW-1:0] cpu_rdata_o,
  input  logic          irq_i,
  output logic          irq_o,
  input  logic          dma_req_i,
  output logic          dma_gnt_o,
  output logic          trusted_o,
  output logic          core_rst_o
);

  logic pc_in_rom, addr_in_key, key_rd;
  logic entering, key_block, viol, hold, mask;

  amon_range #(.AW(AW), .BASE(ROM_BASE), .SIZE(ROM_SIZE)) u_rom_dec (
    .addr_i (pc_i),
    .hit_o  (pc_in_rom)
  );

  amon_range #(.AW(AW), .BASE(KEY_BASE), .SIZE(KEY_LEN)) u_key_dec (
    .addr_i (dbus_addr_i),
    .hit_o  (addr_in_key)
  );

  assign key_rd = dbus_rd_i && addr_in_key;

  amon_seq #(.AW(AW), .ROM_ENTRY(ROM_ENTRY), .ROM_EXIT(ROM_EXIT)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .hold_i      (hold),
    .fetch_i     (pc_valid_i),
    .pc_i        (pc_i),
    .pc_in_rom_i (pc_in_rom),
    .key_rd_i    (key_rd),
    .trusted_o   (trusted_o),
    .entering_o  (entering),
    .key_block_o (key_block),
    .viol_o      (viol)
  );

  amon_rst_pulse #(.RST_LEN(RST_LEN)) u_pulse (
    .clk    (clk),
    .rst_n  (rst_n),
    .trig_i (viol),
    .rst_o  (core_rst_o)
  );

  assign hold = core_rst_o;
  assign mask = trusted_o || entering;

  assign cpu_rdata_o = key_block ? '0 : mem_rdata_i;
  assign irq_o       = irq_i && !mask;
  assign dma_gnt_o   = dma_req_i && !mask;

  AST_KEY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (key_rd && !trusted_o) |-> (cpu_rdata_o == '0)); // R2
  AST_BAD_ENTRY_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_valid_i && pc_in_rom && !trusted_o && !core_rst_o &&
     pc_i != AW'(ROM_ENTRY)) |=> core_rst_o); // R5
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    trusted_o |-> !irq_o); // R8
  AST_DMA_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    trusted_o |-> !dma_gnt_o); // R9
  AST_RST_CLEARS_TRUST: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst_o |-> !trusted_o); // R10

endmodule

// File: tb/key_access_monitor_tb_top.sv
module key_access_monitor_tb_top;

  localparam int unsigned AW        = 16;
  localparam int unsigned DW        = 8;
  localparam int unsigned ROM_BASE  = 'hE000;
  localparam int unsigned ROM_SIZE  = 'h0100;
  localparam int unsigned ROM_ENTRY = 'hE010;
  localparam int unsigned ROM_EXIT  = 'hE0F0;
  localparam int unsigned KEY_BASE  = 'h0A00;
  localparam int unsigned KEY_LEN   = 16;
  localparam int unsigned RST_LEN   = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] pc = '0;
  logic          pc_valid = 1'b0;
  logic [AW-1:0] daddr = '0;
  logic          drd = 1'b0;
  logic [DW-1:0] mem = '0;
  logic [DW-1:0] rdata;
  logic          irq = 1'b0, irq_o, dreq = 1'b0, dgnt, trusted, core_rst;

  int n_chk = 0;
  int n_fail = 0;

  // reference model state
  logic          m_tr = 1'b0;
  logic [AW-1:0] m_last = '0;
  int            m_cnt = 0;

  always #5 clk = ~clk;

  key_access_monitor #(
    .AW(AW), .DW(DW), .ROM_BASE(ROM_BASE), .ROM_SIZE(ROM_SIZE),
    .ROM_ENTRY(ROM_ENTRY), .ROM_EXIT(ROM_EXIT), .KEY_BASE(KEY_BASE),
    .KEY_LEN(KEY_LEN), .RST_LEN(RST_LEN)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .pc_i(pc), .pc_valid_i(pc_valid),
    .dbus_addr_i(daddr), .dbus_rd_i(drd), .mem_rdata_i(mem),
    .cpu_rdata_o(rdata), .irq_i(irq), .irq_o(irq_o), .dma_req_i(dreq),
    .dma_gnt_o(dgnt), .trusted_o(trusted), .core_rst_o(core_rst)
  );

  function automatic logic in_rom(logic [AW-1:0] a);
    return (a >= AW'(ROM_BASE)) && (a <= AW'(ROM_BASE + ROM_SIZE - 1));
  endfunction

  function automatic logic in_key(logic [AW-1:0] a);
    return (a >= AW'(KEY_BASE)) && (a <= AW'(KEY_BASE + KEY_LEN - 1));
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // One cycle: drive on falling edge, check same-cycle outputs, advance model,
  // check registered outputs after the rising edge.
  task automatic step(logic fv, logic [AW-1:0] p, logic rd, logic [AW-1:0] a,
                      logic [DW-1:0] md, logic ir, logic dq);
    logic hold, krd, allowed, entering, mask, viol, leaving, exp_tr;
    string tr_tag;
    @(negedge clk);
    pc = p; pc_valid = fv; drd = rd; daddr = a; mem = md; irq = ir; dreq = dq;
    #1;
    hold     = (m_cnt != 0);
    krd      = rd && in_key(a);
    allowed  = m_tr && in_rom(p);
    entering = !hold && fv && (p == AW'(ROM_ENTRY)) && !m_tr;
    mask     = m_tr || entering;
    check((krd && !allowed) ? "R2 key data" : "R3 read data", 32'(rdata),
          (krd && !allowed) ? 32'd0 : 32'(md));
    check("R8 irq mask", 32'(irq_o), 32'(ir && !mask));
    check("R9 dma block", 32'(dgnt), 32'(dq && !mask));
    leaving = fv && !in_rom(p) && m_tr;
    viol = !hold && ((krd && !allowed) ||
                     (fv && in_rom(p) && p != AW'(ROM_ENTRY) && !m_tr) ||
                     (leaving && m_last != AW'(ROM_EXIT)));
    if (hold)            begin exp_tr = 1'b0; tr_tag = "R11 no trust in pulse"; end
    else if (viol)       begin exp_tr = 1'b0; tr_tag = "R10 viol clears flag"; end
    else if (entering)   begin exp_tr = 1'b1; tr_tag = "R4 entry sets flag"; end
    else if (leaving)    begin exp_tr = 1'b0; tr_tag = "R6 exit clears flag"; end
    else                 begin exp_tr = m_tr; tr_tag = "R4 flag held"; end
    m_tr  = exp_tr;
    if (fv) m_last = p;
    if (viol) m_cnt = RST_LEN;
    else if (m_cnt != 0) m_cnt = m_cnt - 1;
    @(posedge clk);
    #1;
    check(tr_tag, 32'(trusted), 32'(exp_tr));
    check(viol ? "R10 pulse start" : (hold ? "R11 pulse length" : "R10 pulse level"),
          32'(core_rst), 32'(m_cnt != 0));
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0, 16'h0100, 1'b0, 16'h0000, 8'h5A, 1'b0, 1'b0);
  endtask

  initial begin : watchdog
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog all requirements actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check("R1 core_rst", 32'(core_rst), 32'd0);
    check("R1 trusted", 32'(trusted), 32'd0);
    irq = 1'b1; dreq = 1'b1; #1;
    check("R1 irq pass", 32'(irq_o), 32'd1);
    check("R1 dma pass", 32'(dgnt), 32'd1);

    // Legal entry, key read inside, interrupt inside, legal exit (R4 R3 R8 R9 R6)
    step(1'b1, 16'h0200, 1'b0, 16'h0, 8'h11, 1'b0, 1'b0);
    step(1'b1, AW'(ROM_ENTRY), 1'b0, 16'h0, 8'h22, 1'b1, 1'b1);
    step(1'b1, 16'hE020, 1'b1, AW'(KEY_BASE + 3), 8'hC3, 1'b1, 1'b1);
    step(1'b1, 16'hE030, 1'b1, AW'(KEY_BASE + KEY_LEN - 1), 8'h7E, 1'b0, 1'b1);
    step(1'b1, AW'(ROM_EXIT), 1'b0, 16'h0, 8'h00, 1'b1, 1'b0);
    step(1'b1, 16'h0300, 1'b0, 16'h0, 8'h00, 1'b1, 1'b1);
    idle(2);

    // Mid-routine jump in (R5) then fetch at entry inside pulse ignored (R11)
    step(1'b1, 16'hE050, 1'b0, 16'h0, 8'h00, 1'b0, 1'b0);
    step(1'b1, AW'(ROM_ENTRY), 1'b1, AW'(KEY_BASE), 8'hAB, 1'b0, 1'b0);
    idle(RST_LEN + 1);

    // Early exit (R7)
    step(1'b1, AW'(ROM_ENTRY), 1'b0, 16'h0, 8'h00, 1'b0, 1'b0);
    step(1'b1, 16'hE040, 1'b0, 16'h0, 8'h00, 1'b0, 1'b0);
    step(1'b1, 16'h0400, 1'b0, 16'h0, 8'h00, 1'b0, 1'b0);
    idle(RST_LEN + 1);

    // Outside key read (R2), boundaries of the key range (R3)
    step(1'b1, 16'h0500, 1'b1, AW'(KEY_BASE - 1), 8'h99, 1'b0, 1'b0);
    step(1'b1, 16'h0502, 1'b1, AW'(KEY_BASE + KEY_LEN), 8'h98, 1'b0, 1'b0);
    step(1'b1, 16'h0504, 1'b1, AW'(KEY_BASE), 8'hF1, 1'b0, 1'b0);
    idle(RST_LEN + 1);

    // Key read on the entry cycle itself is not yet trusted (R2)
    step(1'b1, AW'(ROM_ENTRY), 1'b1, AW'(KEY_BASE + 1), 8'h44, 1'b1, 1'b1);
    idle(RST_LEN + 1);

    // Constrained random
    for (int i = 0; i < 3000; i++) begin
      logic [AW-1:0] p, a;
      int sel;
      sel = int'($urandom_range(0, 9));
      case (sel)
        0, 1:    p = AW'(ROM_ENTRY);
        2, 3:    p = AW'(ROM_EXIT);
        4, 5, 6: p = AW'(ROM_BASE + $urandom_range(0, ROM_SIZE - 1));
        default: p = AW'($urandom_range(0, 'hDFFF));
      endcase
      a = ($urandom_range(0, 1) == 1) ? AW'(KEY_BASE + $urandom_range(0, KEY_LEN - 1))
                                      : AW'($urandom_range(0, 'hFFFF));
      step($urandom_range(0, 3) != 0, p, $urandom_range(0, 4) == 0, a,
           DW'($urandom), $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule